// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

A single-clock synchronous static memory in which reads and writes may alternate on every clock without an idle cycle between them. An operation is launched with an address and a command. It then travels through two registered stages. A read returns its word on the output register at the second enabled edge after launch. A write takes its data from the data input at that same second edge. Because both directions have the same latency, the shared data bus never needs a turnaround slot.

Write data first lands in a one-entry write register and reaches the array one enabled edge later. A read that follows closely merges the bytes held in that register over the array word, so it always returns the newest value. A two-bit burst counter lets one launch be followed by continue cycles. The counter steps the low address bits in linear or interleaved order and keeps the command type that was chosen at launch.

A clock-enable stall freezes every register. A sleep input idles the block. Three chip enables qualify each launch. Separate data-in, data-out and drive-enable ports stand in for a bidirectional bus.

Top module: `zt_sram`

## Requirements
- R1: With `adv_ld` low, an enabled edge launches a new command: it captures `addr`, `bwe_n`, `burst_ilv` and the type from `we_n` (0 = write, 1 = read). With `adv_ld` high, `we_n`, `addr` and `bwe_n` are ignored and the burst continues with the launched type.
- R2: A launch selects the device only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. Any other combination is a deselect: nothing is written and `dout_oe` stays low. Continue cycles after a deselect remain deselects.
- R3: Read data is on `dout` after the second enabled edge that follows the launch edge, with `dout_oe` high when `oe_n` is low.
- R4: Write data is taken from `din` at the second enabled edge after the launch. Byte i (`din[8i+7:8i]`) is written only when `bwe_n[i]` was 0 at launch. A write with `bwe_n` all ones changes nothing.
- R5: With `burst_ilv`=0 at launch, the k-th continue uses low address bits (start+k) mod 4. The upper address bits do not change.
- R6: With `burst_ilv`=1 at launch, the k-th continue uses low address bits start XOR k.
- R7: An edge with `cke_n`=1 changes no state: `dout` and `dout_oe` hold and no write data is taken or committed.
- R8: A read always returns the newest data for its address, including a read launched on the cycle right after a write, partial byte writes included.
- R9: `dout_oe` is low while `oe_n` is high and during every write data cycle, whatever `oe_n` is.
- R10: While `sleep` is high, `dout_oe` is low. While `sleep` is high and for two clock edges after it falls, all other inputs are ignored and each edge acts as a deselect launch.
- R11: A clock edge with `rst_n` low empties the pipeline: `dout_oe` is low afterwards and no pending write survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cke_n | input | 1 | Clock enable, active low; high stalls the edge |
| sel_a_n | input | 1 | Chip enable, active low |
| sel_b_n | input | 1 | Chip enable, active low |
| sel_c | input | 1 | Chip enable, active high |
| adv_ld | input | 1 | 0 = launch new command, 1 = continue burst |
| we_n | input | 1 | Command type at launch: 0 write, 1 read |
| bwe_n | input | NBYTES | Byte write enables, active low, sampled at launch |
| burst_ilv | input | 1 | Burst order at launch: 0 linear, 1 interleaved |
| addr | input | AW | Word address |
| din | input | NBYTES*8 | Write data, two enabled edges after launch |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| dout | output | NBYTES*8 | Read data register |
| dout_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench targets a read launched right after a write to the same word, including a partial byte write. A block without the write-register bypass would return the old word. It also runs bursts that wrap inside four words in both orders, where a wrong counter reads the neighbouring block or the wrong permutation. Continue cycles carry the opposite read/write level and fresh byte enables; a design that resampled them would flip the burst type. A stall is placed on the exact edge where write data is due. A design that did not freeze would commit the junk on `din` or drop the driven read word. Deselect, abort, output-enable and sleep cases check that nothing is written and that the drivers stay off.

// File: rtl/zt_sram_pkg.sv
// Shared types for the zero-turnaround SRAM.
// Assumes: one command per enabled clock edge.
package zt_sram_pkg;
    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } zt_op_e;
endpackage

// File: rtl/zt_sram_cmd.sv
// Command stage: launch/continue decode, chip select, burst counter and
// sleep window. Produces the operation issued at the last enabled edge.
// Assumes AW >= 2 (the burst counter replaces the two low address bits).
module zt_sram_cmd
    import zt_sram_pkg::*;
#(
    parameter int AW     = 4,
    parameter int NBYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sleep,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bwe_n,
    input  logic              burst_ilv,
    input  logic [AW-1:0]     addr,
    output logic              en,
    output zt_op_e            op,
    output logic [AW-1:0]     op_addr,
    output logic [NBYTES-1:0] op_be_n
);
    localparam logic [1:0] WAKE_EDGES = 2'd2;

    logic [1:0]        wake_cnt;
    logic              ignore;
    logic              load;
    logic              chip_on;
    zt_op_e            op_q;
    logic [AW-1:0]     base_q;
    logic [1:0]        cnt_q;
    logic [NBYTES-1:0] be_q;
    logic              ilv_q;
    logic [1:0]        lo;

    // Sleep exit window: counts edges after sleep falls.
    always_ff @(posedge clk) begin
        if (!rst_n)               wake_cnt <= '0;
        else if (sleep)           wake_cnt <= WAKE_EDGES;
        else if (wake_cnt != 2'd0) wake_cnt <= wake_cnt - 2'd1;
    end

    assign ignore  = sleep | (wake_cnt != 2'd0);
    assign en      = ~cke_n | ignore;
    assign load    = ignore | ~adv_ld;
    assign chip_on = ~sel_a_n & ~sel_b_n & sel_c & ~ignore;

    // Command register: launch captures, continue steps the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q   <= OP_IDLE;
            base_q <= '0;
            cnt_q  <= '0;
            be_q   <= '1;
            ilv_q  <= 1'b0;
        end else if (en) begin
            if (load) begin
                op_q   <= !chip_on ? OP_IDLE : (we_n ? OP_RD : OP_WR);
                base_q <= addr;
                cnt_q  <= '0;
                be_q   <= bwe_n;
                ilv_q  <= burst_ilv;
            end else begin
                cnt_q  <= cnt_q + 2'd1;
            end
        end
    end

    // Burst address: linear add or interleaved XOR on the low two bits.
    always_comb begin
        lo      = ilv_q ? (base_q[1:0] ^ cnt_q) : (base_q[1:0] + cnt_q);
        op_addr = base_q;
        op_addr[1:0] = lo;
    end

    assign op      = op_q;
    assign op_be_n = be_q;

    assert_cont_keeps_type_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (op_q == $past(op_q)));
    assert_cont_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !load) |=> (cnt_q == $past(cnt_q) + 2'd1));
    assert_deselect_launch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ignore && !adv_ld && (sel_a_n || sel_b_n || !sel_c)) |=> (op_q == OP_IDLE));
    assert_sleep_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ignore) |=> (op_q == OP_IDLE));
endmodule

// File: rtl/zt_sram_core.sv
// Storage stage: array, one-entry write register with byte merge bypass,
// and the read output register.
// Assumes DEPTH = 2**AW and at most one write between launch and commit.
module zt_sram_core
    import zt_sram_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int NBYTES = 4,
    parameter int AW     = $clog2(DEPTH),
    parameter int DW     = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  zt_op_e            s2_op,
    input  logic [AW-1:0]     s2_addr,
    input  logic [NBYTES-1:0] s2_be_n,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     rd_data,
    output logic              rd_vld
);
    logic [DW-1:0]     mem [DEPTH];
    logic              wb_vld;
    logic [AW-1:0]     wb_addr;
    logic [NBYTES-1:0] wb_be_n;
    logic [DW-1:0]     wb_data;
    logic [DW-1:0]     merged;

    // Commit the held write into the array on the next enabled edge.
    always_ff @(posedge clk) begin
        if (en && wb_vld) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (!wb_be_n[b]) mem[wb_addr][b*8 +: 8] <= wb_data[b*8 +: 8];
            end
        end
    end

    // Write register: takes din when a write reaches this stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld  <= 1'b0;
            wb_addr <= '0;
            wb_be_n <= '1;
            wb_data <= '0;
        end else if (en) begin
            wb_vld <= (s2_op == OP_WR);
            if (s2_op == OP_WR) begin
                wb_addr <= s2_addr;
                wb_be_n <= s2_be_n;
                wb_data <= din;
            end
        end
    end

    // Bypass: overlay bytes of the uncommitted write on the array word.
    always_comb begin
        merged = mem[s2_addr];
        for (int b = 0; b < NBYTES; b++) begin
            if (wb_vld && (wb_addr == s2_addr) && !wb_be_n[b])
                merged[b*8 +: 8] = wb_data[b*8 +: 8];
        end
    end

    // Read output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld  <= 1'b0;
            rd_data <= '0;
        end else if (en) begin
            rd_vld <= (s2_op == OP_RD);
            if (s2_op == OP_RD) rd_data <= merged;
        end
    end

    assert_write_cycle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_WR) |=> !rd_vld);
    assert_stall_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> ($stable(rd_data) && $stable(rd_vld) && $stable(wb_vld)));
    assert_bypass_full_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en && s2_op == OP_RD && wb_vld && wb_addr == s2_addr && wb_be_n == '0)
        |=> (rd_data == $past(wb_data)));
endmodule

// File: rtl/zt_sram.sv
// Top: command stage, second pipeline register, storage stage and the
// output enable gate. Read and write both complete two enabled edges
// after launch. Assumes DEPTH is a power of two and at least 4.
module zt_sram
    import zt_sram_pkg::*;
#(
    parameter  int DEPTH  = 16,
    parameter  int NBYTES = 4,
    localparam int AW     = $clog2(DEPTH),
    localparam int DW     = NBYTES * 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke_n,
    input  logic              sel_a_n,
    input  logic              sel_b_n,
    input  logic              sel_c,
    input  logic              adv_ld,
    input  logic              we_n,
    input  logic [NBYTES-1:0] bwe_n,
    input  logic              burst_ilv,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     din,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DW-1:0]     dout,
    output logic              dout_oe
);
    logic              en;
    zt_op_e            s1_op;
    logic [AW-1:0]     s1_addr;
    logic [NBYTES-1:0] s1_be_n;
    zt_op_e            s2_op;
    logic [AW-1:0]     s2_addr;
    logic [NBYTES-1:0] s2_be_n;
    logic              rd_vld;

    zt_sram_cmd #(.AW(AW), .NBYTES(NBYTES)) u_cmd (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sleep(sleep),
        .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .adv_ld(adv_ld), .we_n(we_n), .bwe_n(bwe_n), .burst_ilv(burst_ilv),
        .addr(addr), .en(en), .op(s1_op), .op_addr(s1_addr), .op_be_n(s1_be_n)
    );

    // Second stage: carries the issued operation one more enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_op   <= OP_IDLE;
            s2_addr <= '0;
            s2_be_n <= '1;
        end else if (en) begin
            s2_op   <= s1_op;
            s2_addr <= s1_addr;
            s2_be_n <= s1_be_n;
        end
    end

    zt_sram_core #(.DEPTH(DEPTH), .NBYTES(NBYTES), .AW(AW), .DW(DW)) u_core (
        .clk(clk), .rst_n(rst_n), .en(en), .s2_op(s2_op), .s2_addr(s2_addr),
        .s2_be_n(s2_be_n), .din(din), .rd_data(dout), .rd_vld(rd_vld)
    );

    // Drivers on only for a read result, output enabled, not asleep.
    assign dout_oe = rd_vld & ~oe_n & ~sleep;

    assert_stage_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en) |=> ($stable(s2_op) && $stable(s2_addr)));
endmodule

// File: tb/zt_sram_bench.sv
// Self-checking bench: table of commands walked by one loop against a
// reference array and burst model, then directed reset/stall/sleep tests.
module zt_sram_bench;
    localparam int DEPTH = 16;
    localparam int NB    = 4;
    localparam bit Y = 1'b1;
    localparam bit N = 1'b0;

    typedef struct packed {
        logic        ld;
        logic        sel;
        logic        wr;
        logic        ilv;
        logic        oe_off;
        logic [1:0]  how;
        logic [3:0]  be_n;
        logic [3:0]  a;
        logic [31:0] d;
    } row_t;

    typedef struct {
        int          op;
        logic [3:0]  a;
        logic [3:0]  be;
        logic [31:0] d;
    } cmd_t;

    localparam int NV = 38;
    localparam row_t VEC [NV] = '{
        '{Y,Y,Y,N,N,2'd0,4'h0,4'd4,32'h40404040}, // R4 R5 linear write burst from 4
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h41414141}, // R1 continue, we/be ignored
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h42424242},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h43434343},
        '{Y,Y,N,Y,N,2'd0,4'hF,4'd5,32'h0},        // R6 interleaved read from 5
        '{N,N,Y,N,N,2'd0,4'h0,4'd0,32'h0},        // R1 write level ignored
        '{N,N,Y,N,N,2'd0,4'h0,4'd0,32'h0},
        '{N,N,Y,N,N,2'd0,4'h0,4'd0,32'h0},
        '{Y,Y,Y,N,N,2'd0,4'hA,4'd6,32'h77665544}, // R4 bytes 0 and 2
        '{Y,Y,N,N,N,2'd0,4'hF,4'd6,32'h0},        // R8 back-to-back read
        '{Y,Y,Y,N,N,2'd0,4'hF,4'd7,32'hFFFFFFFF}, // R4 abort
        '{Y,Y,N,N,N,2'd0,4'hF,4'd7,32'h0},
        '{Y,N,Y,N,N,2'd2,4'h0,4'd7,32'h12345678}, // R2 sel_c low
        '{N,N,Y,N,N,2'd0,4'h0,4'd7,32'h12345678}, // R2 continue deselect
        '{Y,Y,N,N,N,2'd0,4'hF,4'd7,32'h0},
        '{Y,Y,N,N,N,2'd0,4'hF,4'd7,32'h0},
        '{Y,Y,Y,Y,Y,2'd0,4'h0,4'd2,32'h20202020}, // R9 oe off as row 14 lands; R6 write
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h21212121},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h22222222},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h23232323},
        '{Y,Y,N,N,N,2'd0,4'hF,4'd0,32'h0},        // R5 linear read from 0
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{Y,Y,N,N,N,2'd0,4'hF,4'd2,32'h0},        // R5 wrap from 2
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{Y,Y,Y,N,N,2'd0,4'h0,4'd9,32'h90909090}, // R5 upper bits kept
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h91919191},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h92929292},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h93939393},
        '{Y,Y,N,Y,N,2'd0,4'hF,4'd8,32'h0},        // R6 interleaved from 8
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0},
        '{Y,N,N,N,N,2'd1,4'hF,4'd0,32'h0},        // R2 sel_b_n high
        '{N,N,N,N,N,2'd0,4'hF,4'd0,32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke_n = 1'b0;
    logic        sel_a_n = 1'b1;
    logic        sel_b_n = 1'b0;
    logic        sel_c = 1'b1;
    logic        adv_ld = 1'b0;
    logic        we_n = 1'b1;
    logic [3:0]  bwe_n = 4'hF;
    logic        burst_ilv = 1'b0;
    logic [3:0]  addr = 4'd0;
    logic [31:0] din = 32'd0;
    logic        oe_n = 1'b0;
    logic        sleep = 1'b0;
    logic [31:0] dout;
    logic        dout_oe;

    int n_chk = 0;
    int n_bad = 0;

    logic [31:0] ref_mem [DEPTH];
    cmd_t p1, p2, cur;
    logic [3:0] b_base;
    logic [1:0] b_cnt;
    logic [3:0] b_be;
    logic       b_ilv;
    int         b_op;

    always #5 clk = ~clk;

    zt_sram #(.DEPTH(DEPTH), .NBYTES(NB)) u_zt_sram (
        .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .sel_a_n(sel_a_n),
        .sel_b_n(sel_b_n), .sel_c(sel_c), .adv_ld(adv_ld), .we_n(we_n),
        .bwe_n(bwe_n), .burst_ilv(burst_ilv), .addr(addr), .din(din),
        .oe_n(oe_n), .sleep(sleep), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // One enabled table step: drive at negedge, sample 2 ns after the edge.
    task automatic step(input row_t r);
        logic [1:0] lo;
        @(negedge clk);
        cke_n = 1'b0;
        adv_ld = ~r.ld;
        we_n = ~r.wr;
        sel_a_n = 1'b0; sel_b_n = 1'b0; sel_c = 1'b1;
        if (!r.sel) begin
            if (r.how == 2'd1)      sel_b_n = 1'b1;
            else if (r.how == 2'd2) sel_c = 1'b0;
            else                    sel_a_n = 1'b1;
        end
        bwe_n = r.be_n; addr = r.a; burst_ilv = r.ilv; oe_n = r.oe_off;
        din = p2.d;
        if (r.ld) begin
            b_op = r.sel ? (r.wr ? 2 : 1) : 0;
            b_base = r.a; b_cnt = 2'd0; b_be = r.be_n; b_ilv = r.ilv;
        end else begin
            b_cnt = b_cnt + 2'd1;
        end
        lo = b_ilv ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
        cur.op = b_op; cur.a = {b_base[3:2], lo}; cur.be = b_be; cur.d = r.d;
        @(posedge clk);
        #2;
        if (p2.op == 2) begin
            for (int b = 0; b < NB; b++)
                if (!p2.be[b]) ref_mem[p2.a][b*8 +: 8] = p2.d[b*8 +: 8];
        end
        if (p2.op == 1) begin
            check("R3/R5/R6/R8 read data", dout, ref_mem[p2.a]);
            check("R3/R9 drive on read", {31'd0, dout_oe}, {31'd0, ~r.oe_off});
        end else begin
            check("R2/R9 drive off", {31'd0, dout_oe}, 32'd0);
        end
        p2 = p1;
        p1 = cur;
    endtask

    // Raw directed cycle.
    task automatic tick(input logic ldv, input logic wrv, input logic selv,
                        input logic [3:0] av, input logic [31:0] dv,
                        input logic stall, input logic slp);
        @(negedge clk);
        adv_ld = ~ldv; we_n = ~wrv; sel_a_n = ~selv; sel_b_n = 1'b0; sel_c = 1'b1;
        bwe_n = 4'h0; addr = av; din = dv; cke_n = stall; sleep = slp;
        burst_ilv = 1'b0; oe_n = 1'b0;
        @(posedge clk);
        #2;
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        p1 = '{0, 4'd0, 4'hF, 32'd0};
        p2 = p1;
        b_op = 0; b_base = 4'd0; b_cnt = 2'd0; b_be = 4'hF; b_ilv = 1'b0;
        repeat (3) @(posedge clk);
        #2;
        check("R11 reset drive off", {31'd0, dout_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) step(VEC[i]);

        // R7: stall on the edge where write data is due.
        tick(Y, N, Y, 4'd5, 32'h0, N, N);          // read 5
        tick(Y, Y, Y, 4'd4, 32'h0, N, N);          // write 4, all bytes
        tick(Y, N, N, 4'd0, 32'h0, N, N);          // read of 5 lands
        check("R3 read before stall", dout, 32'h41414141);
        check("R3 drive before stall", {31'd0, dout_oe}, 32'd1);
        tick(Y, N, Y, 4'd7, 32'hDEADBEEF, Y, N);   // stalled edge
        check("R7 data held in stall", dout, 32'h41414141);
        check("R7 drive held in stall", {31'd0, dout_oe}, 32'd1);
        tick(Y, N, N, 4'd0, 32'hC0FFEE00, N, N);   // write data taken here
        check("R9 drive off in write cycle", {31'd0, dout_oe}, 32'd0);
        tick(Y, N, Y, 4'd4, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        check("R7 no commit during stall", dout, 32'hC0FFEE00);

        // R10: sleep forces drive off and ignores a write plus the exit window.
        tick(Y, N, Y, 4'd5, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        check("R10 read before sleep", {31'd0, dout_oe}, 32'd1);
        @(negedge clk);
        sleep = 1'b1; adv_ld = 1'b0; we_n = 1'b0; sel_a_n = 1'b0; addr = 4'd5;
        bwe_n = 4'h0; din = 32'h55555555;
        #1;
        check("R10 drive off in sleep", {31'd0, dout_oe}, 32'd0);
        @(posedge clk);
        #2;
        tick(Y, Y, Y, 4'd5, 32'h55555555, N, N);   // exit window edge 1
        tick(Y, Y, Y, 4'd5, 32'h55555555, N, N);   // exit window edge 2
        tick(Y, N, N, 4'd0, 32'h55555555, N, N);
        tick(Y, N, N, 4'd0, 32'h55555555, N, N);
        check("R10 sleep write ignored drive", {31'd0, dout_oe}, 32'd0);
        tick(Y, N, Y, 4'd5, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        check("R10 sleep write ignored data", dout, 32'h41414141);

        // R11: reset kills an in-flight read.
        tick(Y, N, Y, 4'd5, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check("R11 reset drops read", {31'd0, dout_oe}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        tick(Y, N, N, 4'd0, 32'h0, N, N);
        check("R11 pipeline empty after reset", {31'd0, dout_oe}, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule